// File: doc/BRIEF.md
# Two-Stage Priority Channel Arbiter

This block picks one channel out of up to seven pending transfer channels and gives it a one-hot grant. That grant starts the channel's access sequence on the shared bus. Each channel carries a software-set priority level. The channel with the highest level wins. Among channels on the same level, the one with the smallest index wins.

A channel takes part only when its enable bit is set and its request line is high. The arbiter decides only at an arbitration point. An arbitration point is a cycle in which no grant is outstanding, or a cycle in which the granted channel raises `xfer_done`. Between arbitration points the grant is frozen. A running transaction is therefore never preempted, even by a new request or a changed level.

The block can also sit in the second of two controllers that share one bus. In that case an input reports that the first controller is requesting, and while it is high no new grant is issued here.

Top module: `dma_prio_arbiter`

## Requirements
- R1: During reset and in the first cycle after reset, `grant_valid` is low and `grant` is all zeros.
- R2: A channel can be granted only if both its `ch_en` bit and its `ch_req` bit are 1. A channel that requests while disabled is never granted.
- R3: At an arbitration point, the channel with the numerically largest 2-bit level wins. The levels are 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. Each channel's level sits in `ch_level[2*i+1:2*i]`.
- R4: Among eligible channels that share the highest level, the lowest channel index wins.
- R5: `grant` has at most one bit set. `grant_valid` is high exactly when a bit of `grant` is set, and `grant_idx` is the index of that bit.
- R6: While `grant_valid` is high and `xfer_done` is low, `grant` stays unchanged on the next cycle. This holds even when higher-level requests arrive or the granted channel drops its request.
- R7: An arbitration point is a clock edge at which `grant_valid` is low or `xfer_done` is high. The grant selected there appears on the outputs in the following cycle.
- R8: If no channel is eligible at an arbitration point, `grant_valid` is low and `grant` is all zeros in the following cycle.
- R9: When `upstream_req` is high at an arbitration point, no grant is issued in the following cycle. An outstanding grant is not withdrawn before its `xfer_done`.
- R10: A change to `ch_level` while a grant is held has no effect on that grant. The new levels are used at the next arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_req | input | NUM_CH | Request line per channel |
| ch_en | input | NUM_CH | Enable bit per channel |
| ch_level | input | NUM_CH*LVL_W | Packed priority level per channel |
| upstream_req | input | 1 | First controller on the shared bus is requesting |
| xfer_done | input | 1 | Granted channel finished its transaction |
| grant | output | NUM_CH | One-hot grant |
| grant_valid | output | 1 | A grant is outstanding |
| grant_idx | output | IDX_W | Index of the granted channel |

## Verification
The bench builds the block with NUM_CH=7, LVL_W=2 and HAS_UPSTREAM=1. Seven channels allow the lowest and the highest index to be checked together with mid-range ties, such as channel 2 against channel 4. The two-bit level covers all four levels. Enabling the upstream option brings the hold-off path within reach, both at an idle arbitration point and at a `xfer_done` point.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   localparam int unsigned DEF_LVL_W = 2;
   localparam int unsigned MAX_CH    = 32;

   typedef enum logic [1:0] {
      LVL_LOW   = 2'b00,
      LVL_MED   = 2'b01,
      LVL_HIGH  = 2'b10,
      LVL_VHIGH = 2'b11
   } level_e;
endpackage

// File: rtl/dma_arb_qualify.sv
module dma_arb_qualify #(
   parameter int unsigned NUM_CH = 7
) (
   input  logic [NUM_CH-1:0] req,
   input  logic [NUM_CH-1:0] en,
   output logic [NUM_CH-1:0] eligible
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign eligible[i] = req[i] & en[i];
   end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int unsigned NUM_CH = 7,
   parameter int unsigned LVL_W  = 2,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [NUM_CH-1:0]       eligible,
   input  logic [NUM_CH*LVL_W-1:0] levels,
   output logic                    pick_any,
   output logic [IDX_W-1:0]        pick_idx,
   output logic [NUM_CH-1:0]       pick_onehot
);
   logic [LVL_W-1:0] best_lvl;

   // Scan upward; a strict compare keeps the lower index on a level tie.
   always_comb begin
      pick_any = 1'b0;
      pick_idx = '0;
      best_lvl = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (eligible[i] &&
             (!pick_any || (levels[i*LVL_W +: LVL_W] > best_lvl))) begin
            pick_any = 1'b1;
            pick_idx = IDX_W'(i);
            best_lvl = levels[i*LVL_W +: LVL_W];
         end
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_oh
      assign pick_onehot[i] = pick_any && (pick_idx == IDX_W'(i));
   end
endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
   parameter int unsigned NUM_CH = 7,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pick_any,
   input  logic [IDX_W-1:0]  pick_idx,
   input  logic [NUM_CH-1:0] pick_onehot,
   input  logic              hold_off,
   input  logic              xfer_done,
   output logic              arb_open,
   output logic              valid_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [NUM_CH-1:0] grant_q
);
   assign arb_open = !valid_q || xfer_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         idx_q   <= '0;
         grant_q <= '0;
      end else if (arb_open) begin
         if (pick_any && !hold_off) begin
            valid_q <= 1'b1;
            idx_q   <= pick_idx;
            grant_q <= pick_onehot;
         end else begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            grant_q <= '0;
         end
      end
   end

   assert_hold_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && !xfer_done |=> valid_q && $stable(grant_q) && $stable(idx_q));

   assert_load_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arb_open && pick_any && !hold_off |=> valid_q && (grant_q == $past(pick_onehot)));

   assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      arb_open && !pick_any |=> !valid_q && (grant_q == '0));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
   parameter int unsigned NUM_CH       = 7,
   parameter int unsigned LVL_W        = dma_arb_pkg::DEF_LVL_W,
   parameter bit          HAS_UPSTREAM = 1'b1,
   localparam int unsigned IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       ch_req,
   input  logic [NUM_CH-1:0]       ch_en,
   input  logic [NUM_CH*LVL_W-1:0] ch_level,
   input  logic                    upstream_req,
   input  logic                    xfer_done,
   output logic [NUM_CH-1:0]       grant,
   output logic                    grant_valid,
   output logic [IDX_W-1:0]        grant_idx
);
   if (NUM_CH < 2 || NUM_CH > dma_arb_pkg::MAX_CH) begin : g_bad_ch
      $error("dma_prio_arbiter: NUM_CH out of range");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("dma_prio_arbiter: LVL_W out of range");
   end

   logic [NUM_CH-1:0] eligible;
   logic              pick_any;
   logic [IDX_W-1:0]  pick_idx;
   logic [NUM_CH-1:0] pick_onehot;
   logic              hold_off;
   logic              arb_open;

   if (HAS_UPSTREAM) begin : g_upstream
      assign hold_off = upstream_req;
   end else begin : g_single
      assign hold_off = 1'b0 & upstream_req;
   end

   dma_arb_qualify #(.NUM_CH(NUM_CH)) u_qualify (
      .req      (ch_req),
      .en       (ch_en),
      .eligible (eligible)
   );

   dma_arb_pick #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
      .eligible    (eligible),
      .levels      (ch_level),
      .pick_any    (pick_any),
      .pick_idx    (pick_idx),
      .pick_onehot (pick_onehot)
   );

   dma_arb_hold #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .pick_any    (pick_any),
      .pick_idx    (pick_idx),
      .pick_onehot (pick_onehot),
      .hold_off    (hold_off),
      .xfer_done   (xfer_done),
      .arb_open    (arb_open),
      .valid_q     (grant_valid),
      .idx_q       (grant_idx),
      .grant_q     (grant)
   );

   assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (grant_valid == (grant != '0)));

   assert_idx_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> grant[grant_idx]);

   assert_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arb_open && pick_any |-> (eligible & pick_onehot) != '0);

   assert_upstream_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      HAS_UPSTREAM && arb_open && upstream_req |=> !grant_valid);
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
   import dma_arb_pkg::*;

   localparam int unsigned N = 7;
   localparam int unsigned W = 2;
   localparam int unsigned IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]   ch_req = '0;
   logic [N-1:0]   ch_en = '0;
   logic [N*W-1:0] ch_level = '0;
   logic upstream_req = 1'b0;
   logic xfer_done = 1'b0;
   logic [N-1:0] grant;
   logic grant_valid;
   logic [IW-1:0] grant_idx;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic       valid;
      int         idx;
      string      tag;
   } exp_t;
   exp_t sb[$];

   logic m_valid = 1'b0;
   int   m_idx = 0;
   level_e lv [N];

   always #5 clk = ~clk;

   dma_prio_arbiter #(.NUM_CH(N), .LVL_W(W), .HAS_UPSTREAM(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en),
      .ch_level(ch_level), .upstream_req(upstream_req), .xfer_done(xfer_done),
      .grant(grant), .grant_valid(grant_valid), .grant_idx(grant_idx)
   );

   function automatic logic [N*W-1:0] pack_levels();
      logic [N*W-1:0] v = '0;
      for (int i = 0; i < N; i++) v[i*W +: W] = lv[i];
      return v;
   endfunction

   // Reference choice: scan from the top, ">=" lets lower indices take ties.
   function automatic int ref_pick(input logic [N-1:0] elig);
      int best = -1;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i] && (best < 0 || int'(lv[i]) >= int'(lv[best]))) best = i;
      end
      return best;
   endfunction

   task automatic step(input logic [N-1:0] req, input logic [N-1:0] en,
                       input logic up, input logic done, input string tag);
      exp_t e;
      int p;
      @(negedge clk);
      ch_req = req; ch_en = en; upstream_req = up; xfer_done = done;
      ch_level = pack_levels();
      if (!m_valid || done) begin
         p = ref_pick(req & en);
         if (up || p < 0) begin m_valid = 1'b0; m_idx = 0; end
         else begin m_valid = 1'b1; m_idx = p; end
      end
      e.valid = m_valid; e.idx = m_idx; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      logic [N-1:0] eg;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            eg = e.valid ? (N'(1) << e.idx) : '0;
            checks++;
            if (grant_valid !== e.valid || grant !== eg ||
                (e.valid && grant_idx !== IW'(e.idx))) begin
               errors++;
               $display("FAIL %s: valid=%0b grant=%b idx=%0d expected valid=%0b grant=%b idx=%0d",
                        e.tag, grant_valid, grant, grant_idx, e.valid, eg, e.idx);
            end
         end
      end
   end

   initial begin : watchdog
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : driver
      for (int i = 0; i < N; i++) lv[i] = LVL_LOW;
      repeat (3) @(negedge clk);
      checks++;
      if (grant_valid !== 1'b0 || grant !== '0) begin
         errors++;
         $display("FAIL R1: valid=%0b grant=%b expected 0/0 in reset", grant_valid, grant);
      end
      rst_n = 1'b1;
      @(posedge clk); #2;
      checks++;
      if (grant_valid !== 1'b0 || grant !== '0) begin
         errors++;
         $display("FAIL R1: valid=%0b grant=%b expected 0/0 after reset", grant_valid, grant);
      end

      step('0, '1, 0, 0, "R8 idle");
      step(7'b0001000, 7'b1110111, 0, 0, "R2 disabled channel ignored");
      step(7'b0001000, 7'b1111111, 0, 0, "R2 single eligible grant");
      step(7'b0001000, 7'b1111111, 0, 0, "R6 hold");
      step(7'b0001000, 7'b1111111, 0, 1, "R7 done regrant same");
      step(7'b0000000, 7'b1111111, 0, 1, "R8 done no requests");

      lv[1] = LVL_LOW; lv[5] = LVL_VHIGH;
      step(7'b0100010, 7'b1111111, 0, 0, "R3 very high beats low");
      lv[1] = LVL_HIGH; lv[2] = LVL_MED;
      step(7'b0000110, 7'b1111111, 0, 1, "R3 high beats medium");

      lv[2] = LVL_MED; lv[4] = LVL_MED;
      step(7'b0010100, 7'b1111111, 0, 1, "R4 tie ch2 over ch4");
      lv[6] = LVL_VHIGH;
      step(7'b1010100, 7'b1111111, 0, 0, "R6 no preempt by very high");
      step(7'b1010000, 7'b1111111, 0, 0, "R6 held after request drop");
      step(7'b1010000, 7'b1111111, 0, 1, "R7 rearbitrate to ch6");

      lv[0] = LVL_VHIGH; lv[6] = LVL_LOW;
      step(7'b1000001, 7'b1111111, 0, 0, "R10 level change no effect mid grant");
      step(7'b1000001, 7'b1111111, 0, 1, "R10 new levels at arbitration point");
      lv[0] = LVL_VHIGH; lv[6] = LVL_VHIGH;
      step(7'b1000001, 7'b1111111, 0, 1, "R4 tie ch0 over ch6");

      step(7'b1000001, 7'b1111111, 1, 0, "R9 upstream no withdraw");
      step(7'b1000001, 7'b1111111, 1, 1, "R9 upstream blocks at done");
      step(7'b1000001, 7'b1111111, 1, 0, "R9 upstream blocks idle");
      step(7'b1000001, 7'b0111111, 0, 0, "R2 regrant after upstream");
      lv[3] = LVL_HIGH;
      step(7'b1111111, 7'b1111111, 0, 1, "R5 all requesting");
      step('0, '0, 0, 1, "R8 all clear");

      @(negedge clk);
      while (sb.size() > 0) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule